// File: doc/BRIEF.md
# Four-channel wiper register SPI slave

This block is the digital front end of a four-channel digital potentiometer. It listens on a four-wire serial bus as a slave. Each frame, framed by an active-low chip select, starts with a fixed device identifier byte. A command byte follows it, naming one of four channels and asking either to load that channel's 8-bit wiper position or to return it. The four wiper registers drive an 8-bit position output each, toward the resistor array outside this block.

The serial pins are oversampled on the system clock. Writes are refused while the write-protect pin is low. A lockout after reset keeps the part silent: it refuses reads for the first millisecond and writes for the first five milliseconds. Both windows are counted in system clock cycles from a clock-frequency parameter.

Top module: `spi_wiper_slave`

## Requirements
- R1: During and right after reset every wiper position is 0x80 and `miso_oe` is low.
- R2: A complete frame of identifier 0x50, command 0xA0 plus channel (0 to 3, in command bits 1:0), and one data byte loads the data into that channel's wiper, which appears on `wiper_pos[8*ch+7:8*ch]`; the other channels keep their values.
- R3: A frame of identifier 0x50 and command 0x90 plus channel makes the slave drive the third byte on `miso`, MSB first, holding that channel's wiper value. The bus is in mode 0: the slave changes data after SCLK falls and the master samples on SCLK rising. `miso_oe` is high during that byte.
- R4: A frame whose first byte is not 0x50 changes no wiper and leaves `miso_oe` low for the whole frame.
- R5: A command whose upper nibble is neither 0x9 nor 0xA, or whose bits 3:2 are not zero, is ignored. No wiper changes and `miso_oe` stays low for the rest of the frame.
- R6: A write whose data byte completes while `wp_n` is low leaves every wiper unchanged.
- R7: Reads decoded within the first RD_LOCK_US microseconds after reset are ignored, and `miso_oe` stays low.
- R8: Writes completing within the first WR_LOCK_US microseconds after reset are ignored.
- R9: A frame cut short by chip select rising before its 24th bit loads nothing. `miso_oe` returns low within a few clock cycles of chip select going high.
- R10: Each channel holds any value from 0x00 to 0xFF independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Chip select, active low, frames a transaction |
| mosi | input | 1 | Serial data from the master, MSB first |
| wp_n | input | 1 | Write protect, low blocks wiper writes |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | High when `miso` should be driven; low means high impedance |
| wiper_pos | output | 32 | Four wiper positions, channel n at bits 8n+7:8n |

## Verification
A wrong bit counter or wrong identifier state shows up at once, in two ways: a loaded value sits in the wrong channel on `wiper_pos`, or a channel does not move within a few cycles of the 24th SCLK edge. A stale or misaligned transmit register returns a read byte that is shifted or taken from the wrong channel. That error is visible during the third byte of the same frame. A lockout counter or protect check that is wrong either lets an early or protected write move a wiper, or lets `miso_oe` rise during the read lockout. Each of these shows in the first frame that tries it.

// File: rtl/spi_wiper_slave.sv
module spi_wiper_slave #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WR_LOCK_US = 5000,
  parameter int RD_LOCK_US = 1000,
  parameter logic [7:0] DEV_ID    = 8'h50,
  parameter logic [7:0] RESET_POS = 8'h80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic        wp_n,
  output logic        miso,
  output logic        miso_oe,
  output logic [31:0] wiper_pos
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int WR_CYC = CYC_PER_US * WR_LOCK_US;
  localparam int RD_CYC = CYC_PER_US * RD_LOCK_US;
  localparam int CW = $clog2(WR_CYC + 1);
  localparam logic [CW-1:0] WR_LIM = CW'(WR_CYC);
  localparam logic [CW-1:0] RD_LIM = CW'(RD_CYC);

  logic [2:0] s_sclk;
  logic [1:0] s_cs, s_mosi;
  logic [CW-1:0] up_cnt;
  logic [4:0] bitcnt;
  logic [7:0] rx, tx;
  logic [1:0] ch;
  logic id_ok, do_wr, skip;
  logic [7:0] wip [4];

  wire sck_rise = s_sclk[1] & ~s_sclk[2];
  wire sck_fall = ~s_sclk[1] & s_sclk[2];
  wire cs_act   = ~s_cs[1];
  wire rd_ok    = up_cnt >= RD_LIM;
  wire wr_ok    = up_cnt >= WR_LIM;
  wire [7:0] rx_next = {rx[6:0], s_mosi[1]};
  wire cmd_legal = id_ok && (rx_next[3:2] == 2'b00);

  assign miso = tx[7];

  for (genvar i = 0; i < 4; i++) begin : g_out
    assign wiper_pos[8*i +: 8] = wip[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sclk  <= '0;
      s_cs    <= '1;
      s_mosi  <= '0;
      up_cnt  <= '0;
      bitcnt  <= '0;
      rx      <= '0;
      tx      <= '0;
      ch      <= '0;
      id_ok   <= 1'b0;
      do_wr   <= 1'b0;
      skip    <= 1'b0;
      miso_oe <= 1'b0;
      for (int i = 0; i < 4; i++) wip[i] <= RESET_POS;
    end else begin
      s_sclk <= {s_sclk[1:0], sclk};
      s_cs   <= {s_cs[0], cs_n};
      s_mosi <= {s_mosi[0], mosi};
      if (!wr_ok) up_cnt <= up_cnt + 1'b1;
      if (!cs_act) begin
        bitcnt  <= '0;
        id_ok   <= 1'b0;
        do_wr   <= 1'b0;
        skip    <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        if (sck_rise && bitcnt != 5'd24) begin
          rx     <= rx_next;
          bitcnt <= bitcnt + 1'b1;
          case (bitcnt)
            5'd7: id_ok <= (rx_next == DEV_ID);
            5'd15: begin
              ch <= rx_next[1:0];
              if (cmd_legal && rx_next[7:4] == 4'h9 && rd_ok) begin
                tx      <= wip[rx_next[1:0]];
                skip    <= 1'b1;
                miso_oe <= 1'b1;
              end
              do_wr <= cmd_legal && rx_next[7:4] == 4'hA;
            end
            5'd23: if (do_wr && wr_ok && wp_n) wip[ch] <= rx_next;
            default: ;
          endcase
        end
        if (sck_fall && miso_oe) begin
          if (skip) skip <= 1'b0;
          else tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_wiper_slave_chk.sv
module spi_wiper_slave_chk #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WR_LOCK_US = 5000,
  parameter int RD_LOCK_US = 1000,
  parameter logic [7:0] DEV_ID    = 8'h50,
  parameter logic [7:0] RESET_POS = 8'h80
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        wp_n,
  input logic        miso_oe,
  input logic [31:0] wiper_pos
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int WR_CYC = CYC_PER_US * WR_LOCK_US;
  localparam int RD_CYC = CYC_PER_US * RD_LOCK_US;
  localparam int CW = $clog2(WR_CYC + 1);
  localparam logic [CW-1:0] WR_LIM = CW'(WR_CYC);
  localparam logic [CW-1:0] RD_LIM = CW'(RD_CYC);

  logic [CW-1:0] cyc;
  logic [2:0] cs_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= '0;
      cs_hi <= '0;
    end else begin
      if (cyc < WR_LIM) cyc <= cyc + 1'b1;
      if (!cs_n) cs_hi <= '0;
      else if (cs_hi != 3'd7) cs_hi <= cs_hi + 1'b1;
    end
  end

  p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper_pos == {4{RESET_POS}} && !miso_oe));

  p_protect_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(wp_n) |-> $stable(wiper_pos));

  p_rd_lockout_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc < RD_LIM) |-> !miso_oe);

  p_wr_lockout_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc < WR_LIM) |=> $stable(wiper_pos));

  p_oe_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_hi >= 3'd5) |-> !miso_oe);
endmodule

bind spi_wiper_slave spi_wiper_slave_chk #(
  .CLK_HZ(CLK_HZ), .WR_LOCK_US(WR_LOCK_US), .RD_LOCK_US(RD_LOCK_US),
  .DEV_ID(DEV_ID), .RESET_POS(RESET_POS)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
  .miso_oe(miso_oe), .wiper_pos(wiper_pos)
);

// File: tb/spi_wiper_slave_bench.sv
module spi_wiper_slave_bench;
  localparam time HALF = 60ns;

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1, mosi = 0, wp_n = 1;
  logic miso, miso_oe;
  logic [31:0] wiper_pos;
  int vectors = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [7:0] rd_byte;
  logic oe_seen;
  logic [7:0] model [4];

  spi_wiper_slave #(.CLK_HZ(1_000_000)) u_spi_wiper_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n),
    .miso(miso), .miso_oe(miso_oe), .wiper_pos(wiper_pos));

  always #5ns clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, input int nbits);
    logic [23:0] w = {b0, b1, b2};
    rd_byte = '0;
    oe_seen = 0;
    cs_n = 0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[23 - i];
      #(HALF);
      if (i >= 16) begin
        rd_byte = {rd_byte[6:0], miso};
        oe_seen |= miso_oe;
      end
      sclk = 1;
      #(HALF);
      sclk = 0;
    end
    #(HALF);
    cs_n = 1;
    #200ns;
  endtask

  function automatic logic [31:0] packed_model();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic t_reset;
    chk(wiper_pos == 32'h80808080 && !miso_oe, "R1 reset state", {wiper_pos[30:0], miso_oe}, {31'h00808080 << 0, 1'b0});
  endtask

  task automatic t_early;
    frame(8'h50, 8'h90, 8'h00, 24);
    chk(!oe_seen, "R7 read lockout oe", oe_seen, 0);
    frame(8'h50, 8'hA1, 8'h11, 24);
    chk(wiper_pos == packed_model(), "R8 write lockout", wiper_pos, packed_model());
  endtask

  task automatic t_write_all;
    logic [7:0] v [4] = '{8'h00, 8'hFF, 8'h3C, 8'hC5};
    for (int c = 0; c < 4; c++) begin
      frame(8'h50, 8'hA0 | 8'(c), v[c], 24);
      model[c] = v[c];
      chk(wiper_pos == packed_model(), "R2 write channel", wiper_pos, packed_model());
    end
    chk(wiper_pos[7:0] == 8'h00 && wiper_pos[15:8] == 8'hFF, "R10 full range", wiper_pos, packed_model());
  endtask

  task automatic t_read_all;
    for (int c = 0; c < 4; c++) begin
      frame(8'h50, 8'h90 | 8'(c), 8'h00, 24);
      chk(oe_seen, "R3 read oe", oe_seen, 1);
      chk(rd_byte == model[c], "R3 read data", rd_byte, model[c]);
    end
  endtask

  task automatic t_bad_id;
    frame(8'h51, 8'hA2, 8'h99, 24);
    chk(wiper_pos == packed_model(), "R4 bad id write", wiper_pos, packed_model());
    frame(8'hD0, 8'h91, 8'h00, 24);
    chk(!oe_seen, "R4 bad id read oe", oe_seen, 0);
  endtask

  task automatic t_bad_cmd;
    frame(8'h50, 8'hB2, 8'h77, 24);
    chk(wiper_pos == packed_model() && !oe_seen, "R5 unknown nibble", {wiper_pos[30:0], oe_seen}, {packed_model() << 1});
    frame(8'h50, 8'h94, 8'h00, 24);
    chk(!oe_seen, "R5 read bits 3:2 set", oe_seen, 0);
    frame(8'h50, 8'hA5, 8'h42, 24);
    chk(wiper_pos == packed_model(), "R5 write bits 3:2 set", wiper_pos, packed_model());
  endtask

  task automatic t_protect;
    wp_n = 0;
    frame(8'h50, 8'hA3, 8'h5A, 24);
    chk(wiper_pos == packed_model(), "R6 protected write", wiper_pos, packed_model());
    wp_n = 1;
    frame(8'h50, 8'hA3, 8'h5A, 24);
    model[3] = 8'h5A;
    chk(wiper_pos == packed_model(), "R6 unprotected write", wiper_pos, packed_model());
  endtask

  task automatic t_abort;
    frame(8'h50, 8'hA2, 8'hE7, 20);
    chk(wiper_pos == packed_model(), "R9 aborted write", wiper_pos, packed_model());
    frame(8'h50, 8'h92, 8'h00, 19);
    chk(oe_seen, "R9 partial read oe", oe_seen, 1);
    chk(!miso_oe, "R9 oe after cs high", miso_oe, 0);
    frame(8'h50, 8'hA2, 8'h01, 24);
    model[2] = 8'h01;
    chk(wiper_pos == packed_model(), "R10 channel independence", wiper_pos, packed_model());
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) model[c] = 8'h80;
    #3ns;
    repeat (5) @(posedge clk);
    #3ns;
    chk(wiper_pos == 32'h80808080 && !miso_oe, "R1 in reset", wiper_pos, 32'h80808080);
    rst = 0;
    @(posedge clk);
    #3ns;
    t_reset();
    t_early();
    wait (cyc > 5100);
    @(posedge clk);
    #3ns;
    t_write_all();
    t_read_all();
    t_bad_id();
    t_bad_cmd();
    t_protect();
    t_abort();
    finish_run();
  end

  initial begin
    #2ms;
    vectors++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end
endmodule